// File: doc/BRIEF.md
# Block-Granular Address Translation Table

This block translates a flat 30-bit bus address into a byte address in flash. The flash is handled in blocks of 16 KiB, and each table entry maps a run of consecutive bus blocks onto a run of consecutive flash blocks. The length of each run is a power of two. Every entry can be enabled for CPU reads, for DMA reads, or for both. An entry can also carry a flag that tells a downstream decryptor to take its chaining data from a fixed IV store rather than from flash.

Software programs an entry in two steps. It first writes a shared staging word that holds the attributes: run length, access enables and IV flag. It then writes the per-entry word, which holds the flash start block and the bus base block. Writing the per-entry word commits the whole entry, taking the attributes from whatever the staging word holds at that moment.

A lookup latches an address and an access type. It then scans every entry, one entry per cycle, and reports the first match with a one-cycle done strobe. A miss is reported when no entry matches. To fetch the cipher block ahead of a region base, software places a one-block entry with the IV flag set directly below that base. A lookup at the base address minus 0x10 then lands on this entry and reports an IV-store hit.

Top module: `blk_xlate_table`

## Requirements
- R1: After reset every entry is invalid, `lk_busy`, `lk_done`, `lk_hit`, `lk_iv` and `lk_faddr` are 0, and any lookup misses.
- R2: A staging write latches these fields of `stg_wdata`: bit 8 is the IV flag, bit 5 is CPU enable, bit 4 is DMA enable, and bits [3:0] are the log2 of the run length in blocks. All other bits are ignored.
- R3: An entry write with `ent_idx` below NUM_ENT makes that entry valid. The entry takes its flash start block from `ent_wdata[31:16]`, its bus base block (bus address divided by 0x4000) from `ent_wdata[15:0]`, and its attributes from the staging word. An entry write with `ent_idx` at or above NUM_ENT changes nothing.
- R4: An entry with log2 field n covers bus blocks base through base+2^n-1. An address below the base, or at base+2^n or above, does not match that entry.
- R5: `lk_is_dma`=1 makes a DMA lookup and `lk_is_dma`=0 makes a CPU lookup. An entry matches only if its enable for that access type is set.
- R6: On a hit, `lk_faddr` = ((flash block + addr[29:14] - base) mod 2^16) * 0x4000 + addr[13:0]. On a miss, `lk_faddr` is 0.
- R7: When several entries match, the entry with the lowest index supplies the result.
- R8: `lk_iv` is 1 exactly when the lookup hits an entry that has the IV flag set.
- R9: A request taken while idle raises `lk_busy` on the next cycle. `lk_done` pulses for one cycle exactly NUM_ENT clock edges after the edge that took the request. `lk_req` is ignored while `lk_busy` is high.
- R10: `lk_hit`, `lk_iv` and `lk_faddr` change only in the cycle in which `lk_done` is high, and hold their values until the next done.
- R11: Writing the staging word after a commit does not alter entries already committed. Rewriting an entry replaces its previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stg_we | input | 1 | Write strobe for the staging word |
| stg_wdata | input | 32 | Staging word data |
| ent_we | input | 1 | Entry commit strobe |
| ent_idx | input | IDX_W | Index of the entry to commit |
| ent_wdata | input | 32 | Flash start block and bus base block |
| lk_req | input | 1 | Lookup request |
| lk_is_dma | input | 1 | Access type: 1 = DMA, 0 = CPU |
| lk_addr | input | 30 | Bus address to translate |
| lk_busy | output | 1 | Scan in progress |
| lk_done | output | 1 | One-cycle result strobe |
| lk_hit | output | 1 | A valid entry matched |
| lk_iv | output | 1 | Chaining data comes from the IV store |
| lk_faddr | output | 30 | Translated flash byte address |

## Verification
On every cycle, the assertions check the handshake and the result outputs. They confirm that done is a single-cycle pulse seen only while idle, that a request taken while idle starts a scan, that the result outputs stay stable outside done, that the IV flag never appears without a hit, and that a miss gives a zero address. Only the bench scenarios can show that the translation itself is correct: the run edges, the type qualification, first-match priority, the IV dummy entry below a region base, the snapshot of the staging word taken at commit, the ignored out-of-range commits, and the exact scan latency. Those scenarios compare the design against an independent table model, using both directed cases and random programming.

// File: rtl/blk_xlate_table.sv
module blk_xlate_table #(
  parameter int NUM_ENT = 192,
  parameter int IDX_W   = $clog2(NUM_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stg_we,
  input  logic [31:0]      stg_wdata,
  input  logic             ent_we,
  input  logic [IDX_W-1:0] ent_idx,
  input  logic [31:0]      ent_wdata,
  input  logic             lk_req,
  input  logic             lk_is_dma,
  input  logic [29:0]      lk_addr,
  output logic             lk_busy,
  output logic             lk_done,
  output logic             lk_hit,
  output logic             lk_iv,
  output logic [29:0]      lk_faddr
);
  localparam int BLK_W = 16;
  localparam int OFS_W = 14;

  logic             s_iv, s_cpu, s_dma;
  logic [3:0]       s_lg;

  logic             e_vld [NUM_ENT];
  logic             e_iv  [NUM_ENT];
  logic             e_cpu [NUM_ENT];
  logic             e_dma [NUM_ENT];
  logic [3:0]       e_lg  [NUM_ENT];
  logic [BLK_W-1:0] e_blk [NUM_ENT];
  logic [BLK_W-1:0] e_base[NUM_ENT];

  logic [IDX_W-1:0] ptr;
  logic [29:0]      a_q;
  logic             dma_q;
  logic             c_hit, c_iv;
  logic [29:0]      c_fa;

  wire              wr_ok = ent_we && (32'(ent_idx) < NUM_ENT);
  wire [BLK_W:0]    diff  = {1'b0, a_q[29:OFS_W]} - {1'b0, e_base[ptr]};
  wire              in_rng = !diff[BLK_W] && ((diff[BLK_W-1:0] >> e_lg[ptr]) == '0);
  wire              ty_ok  = dma_q ? e_dma[ptr] : e_cpu[ptr];
  wire              match  = e_vld[ptr] && ty_ok && in_rng;
  wire [BLK_W-1:0]  f_blk  = e_blk[ptr] + diff[BLK_W-1:0];
  wire [29:0]       fa     = {f_blk, a_q[OFS_W-1:0]};
  wire              last   = (32'(ptr) == NUM_ENT - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {s_iv, s_cpu, s_dma, s_lg} <= '0;
    end else if (stg_we) begin
      {s_iv, s_cpu, s_dma, s_lg} <= {stg_wdata[8], stg_wdata[5], stg_wdata[4], stg_wdata[3:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ENT; i++) e_vld[i] <= 1'b0;
    end else if (wr_ok) begin
      e_vld[ent_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) begin
      e_iv[ent_idx]   <= s_iv;
      e_cpu[ent_idx]  <= s_cpu;
      e_dma[ent_idx]  <= s_dma;
      e_lg[ent_idx]   <= s_lg;
      e_blk[ent_idx]  <= ent_wdata[31:16];
      e_base[ent_idx] <= ent_wdata[15:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_busy <= 1'b0;
      lk_done <= 1'b0;
      ptr     <= '0;
      a_q     <= '0;
      dma_q   <= 1'b0;
      c_hit   <= 1'b0;
      c_iv    <= 1'b0;
      c_fa    <= '0;
      lk_hit  <= 1'b0;
      lk_iv   <= 1'b0;
      lk_faddr <= '0;
    end else begin
      lk_done <= 1'b0;
      if (!lk_busy && lk_req) begin
        lk_busy <= 1'b1;
        ptr     <= '0;
        a_q     <= lk_addr;
        dma_q   <= lk_is_dma;
        c_hit   <= 1'b0;
        c_iv    <= 1'b0;
        c_fa    <= '0;
      end else if (lk_busy) begin
        if (match && !c_hit) begin
          c_hit <= 1'b1;
          c_iv  <= e_iv[ptr];
          c_fa  <= fa;
        end
        if (last) begin
          lk_busy  <= 1'b0;
          lk_done  <= 1'b1;
          lk_hit   <= c_hit | match;
          lk_iv    <= c_hit ? c_iv : (match & e_iv[ptr]);
          lk_faddr <= c_hit ? c_fa : (match ? fa : '0);
        end else begin
          ptr <= ptr + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/blk_xlate_table_chk.sv
module blk_xlate_table_chk #(
  parameter int NUM_ENT = 192,
  parameter int IDX_W   = $clog2(NUM_ENT)
) (
  input logic        clk,
  input logic        rst_n,
  input logic        lk_req,
  input logic        lk_busy,
  input logic        lk_done,
  input logic        lk_hit,
  input logic        lk_iv,
  input logic [29:0] lk_faddr
);
  p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && !lk_busy) |=> lk_busy);
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lk_done |=> !lk_done);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lk_done |-> !lk_busy);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_done |-> $stable({lk_hit, lk_iv, lk_faddr}));
  p_iv_needs_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lk_iv |-> lk_hit);
  p_miss_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_faddr == '0));
endmodule

bind blk_xlate_table blk_xlate_table_chk #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_busy(lk_busy),
  .lk_done(lk_done), .lk_hit(lk_hit), .lk_iv(lk_iv), .lk_faddr(lk_faddr)
);

// File: tb/sim_blk_xlate_table.sv
module sim_blk_xlate_table;
  localparam int CLK_PERIOD = 10;
  localparam int N = 192;
  localparam int IW = 8;

  logic clk = 0, rst_n = 0;
  logic stg_we = 0, ent_we = 0, lk_req = 0, lk_is_dma = 0;
  logic [31:0] stg_wdata = '0, ent_wdata = '0;
  logic [IW-1:0] ent_idx = '0;
  logic [29:0] lk_addr = '0;
  logic lk_busy, lk_done, lk_hit, lk_iv;
  logic [29:0] lk_faddr;

  int total = 0, fails = 0, cyc = 0;

  logic [31:0] m_stg;
  logic        m_vld [N];
  logic [31:0] m_att [N];
  logic [15:0] m_blk [N];
  logic [15:0] m_base[N];

  always #(CLK_PERIOD/2) clk = ~clk;

  blk_xlate_table #(.NUM_ENT(N)) u0 (
    .clk(clk), .rst_n(rst_n), .stg_we(stg_we), .stg_wdata(stg_wdata),
    .ent_we(ent_we), .ent_idx(ent_idx), .ent_wdata(ent_wdata),
    .lk_req(lk_req), .lk_is_dma(lk_is_dma), .lk_addr(lk_addr),
    .lk_busy(lk_busy), .lk_done(lk_done), .lk_hit(lk_hit), .lk_iv(lk_iv),
    .lk_faddr(lk_faddr)
  );

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
      finish_run();
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] stgw(input logic iv, input logic cpu, input logic dma, input logic [3:0] lg);
    return {23'd0, iv, 2'b00, cpu, dma, lg};
  endfunction

  function automatic logic [31:0] model(input logic [29:0] a, input logic dma);
    for (int i = 0; i < N; i++) begin
      int off;
      logic en;
      off = int'(a[29:14]) - int'(m_base[i]);
      en  = dma ? m_att[i][4] : m_att[i][5];
      if (m_vld[i] && en && off >= 0 && off < (1 << m_att[i][3:0])) begin
        logic [15:0] fb;
        fb = 16'(int'(m_blk[i]) + off);
        return {1'b1, m_att[i][8], fb, a[13:0]};
      end
    end
    return '0;
  endfunction

  task automatic stage(input logic [31:0] w);
    @(negedge clk); stg_we = 1; stg_wdata = w;
    @(negedge clk); stg_we = 0;
    m_stg = w;
  endtask

  task automatic commit(input int idx, input logic [15:0] blk, input logic [15:0] base);
    @(negedge clk); ent_we = 1; ent_idx = IW'(idx); ent_wdata = {blk, base};
    @(negedge clk); ent_we = 0;
    if (idx < N) begin
      m_vld[idx] = 1; m_att[idx] = m_stg; m_blk[idx] = blk; m_base[idx] = base;
    end
  endtask

  task automatic look(input logic [29:0] a, input logic d, input logic poke,
                      output logic [31:0] r, output int lat);
    @(negedge clk); lk_req = 1; lk_addr = a; lk_is_dma = d;
    @(negedge clk); lk_req = 0; lat = 0;
    while (!lk_done && lat < N + 20) begin
      if (poke && lat == 3) begin lk_req = 1; lk_addr = ~a; lk_is_dma = ~d; end
      else lk_req = 0;
      @(negedge clk); lat++;
    end
    lk_req = 0;
    r = {lk_hit, lk_iv, lk_faddr};
  endtask

  task automatic probe(input logic [29:0] a, input logic d, input string req);
    logic [31:0] r, e;
    int lat;
    look(a, d, 1'b0, r, lat);
    e = model(a, d);
    chk(r == e, req, r, e);
    chk(lat == N, "R9 latency", 32'(lat), 32'(N));
  endtask

  initial begin
    logic [31:0] r, e;
    int lat;
    void'($urandom(32'd2718));
    m_stg = '0;
    for (int i = 0; i < N; i++) begin
      m_vld[i] = 0; m_att[i] = '0; m_blk[i] = '0; m_base[i] = '0;
    end
    repeat (3) @(negedge clk);
    chk({lk_busy, lk_done, lk_hit, lk_iv, lk_faddr} == '0, "R1 outputs in reset",
        32'({lk_busy, lk_done, lk_hit, lk_iv}), 0);
    rst_n = 1;
    @(negedge clk);
    chk(lk_busy == 0 && lk_done == 0, "R1 idle after reset", 32'({lk_busy, lk_done}), 0);
    look(30'h1000_0000, 1'b0, 1'b0, r, lat);
    chk(r == 0, "R1 empty table misses", r, 0);
    chk(lat == N, "R9 latency", 32'(lat), 32'(N));
    look(30'h1000_0000, 1'b1, 1'b0, r, lat);
    chk(r == 0, "R1 empty table misses dma", r, 0);

    // R2: stray bits around the fields are ignored
    stage(32'hFFFF_FEC0 | stgw(0, 1, 1, 4'd4));
    m_stg = stgw(0, 1, 1, 4'd4);
    commit(5, 16'h0100, 16'h4000);
    probe(30'h1000_0000, 1'b0, "R6 base of run");
    chk(lk_faddr == 30'h0040_0000, "R6 base address", 32'(lk_faddr), 32'h0040_0000);
    probe(30'h1003_C123, 1'b1, "R4 last block of run");
    chk(lk_faddr == {16'h010F, 14'h0123}, "R4 last block address", 32'(lk_faddr), 32'({16'h010F, 14'h0123}));
    probe(30'h1004_0000, 1'b0, "R4 one past run");
    chk(lk_hit == 0, "R4 past run misses", 32'(lk_hit), 0);
    probe(30'h0FFF_FFF0, 1'b0, "R4 below base");

    stage(stgw(1, 0, 1, 4'd0));
    commit(4, 16'h0000, 16'h3FFF);
    probe(30'h0FFF_FFF0, 1'b1, "R8 iv dummy dma");
    chk(lk_hit && lk_iv, "R8 iv flagged", 32'({lk_hit, lk_iv}), 32'h3);
    probe(30'h0FFF_FFF0, 1'b0, "R5 iv dummy not for cpu");
    chk(!lk_hit, "R5 cpu skips dma-only", 32'(lk_hit), 0);

    stage(stgw(0, 1, 0, 4'd0));
    commit(7, 16'h0020, 16'h5000);
    probe(30'h1400_0010, 1'b0, "R5 cpu-only hit");
    probe(30'h1400_0010, 1'b1, "R5 cpu-only dma miss");
    chk(!lk_hit, "R5 dma misses cpu-only", 32'(lk_hit), 0);

    stage(stgw(0, 1, 1, 4'd0));
    commit(2, 16'h0999, 16'h4000);
    probe(30'h1000_0044, 1'b1, "R7 lowest index wins");
    chk(lk_faddr[29:14] == 16'h0999, "R7 winner block", 32'(lk_faddr[29:14]), 32'h0999);

    stage(stgw(0, 0, 0, 4'd0));
    probe(30'h1000_C000, 1'b0, "R11 staging after commit");
    chk(lk_hit == 1, "R11 committed entry kept", 32'(lk_hit), 1);
    commit(2, 16'h0999, 16'h4000);
    probe(30'h1000_0044, 1'b1, "R11 rewrite replaces entry");
    chk(lk_faddr[29:14] == 16'h0100, "R11 falls to next entry", 32'(lk_faddr[29:14]), 32'h0100);

    stage(stgw(0, 1, 1, 4'd2));
    commit(200, 16'h0300, 16'h6000);
    probe(30'h1800_0000, 1'b0, "R3 out-of-range index ignored");
    chk(lk_hit == 0, "R3 no entry from bad index", 32'(lk_hit), 0);
    commit(N - 1, 16'h0300, 16'h6000);
    probe(30'h1800_8000, 1'b1, "R3 last index commits");
    chk(lk_hit == 1, "R3 last entry hits", 32'(lk_hit), 1);

    look(30'h1000_0000, 1'b0, 1'b1, r, lat);
    e = model(30'h1000_0000, 1'b0);
    chk(r == e, "R9 request while busy ignored", r, e);
    chk(lat == N, "R9 latency with extra request", 32'(lat), 32'(N));
    @(negedge clk);
    chk(lk_busy == 0, "R9 extra request not queued", 32'(lk_busy), 0);
    repeat (5) @(negedge clk);
    chk({lk_hit, lk_iv, lk_faddr} == e, "R10 result held", {lk_hit, lk_iv, lk_faddr}, e);

    for (int k = 0; k < 60; k++) begin
      int nw;
      nw = $urandom_range(0, 3);
      for (int j = 0; j < nw; j++) begin
        stage({$urandom} & 32'hFFFF_FFFF);
        m_stg = m_stg;
        commit($urandom_range(0, 220), 16'($urandom), 16'($urandom_range(16'h3FF0, 16'h4050)));
      end
      probe({16'($urandom_range(16'h3FF0, 16'h4060)), 14'($urandom)}, 1'($urandom),
            "R6 random translation");
    end

    finish_run();
  end
endmodule